// File: doc/BRIEF.md
# Serial Transmit Buffer with Character Timer

This block is the transmit control path of a byte-oriented asynchronous serial port. A CPU byte bus writes four registers: a frame-mode register, a bit-rate divisor, a control register and a transmit data register. The block keeps a one-deep holding register in front of the shift stage and maintains two status flags. `flagTdre` means the holding register is free. `flagTend` means the transmitter is idle with nothing queued.

Each time a character starts, the block hands the byte to a downstream bit shifter as a single-cycle `txValid` strobe and loads a down-counter with one character time. The character time is measured in input clocks and comes from the frame format and rate settings. When the counter runs out, the block either launches the byte waiting in the holding register or declares the end of transmission.

The block has two interrupts. `txEmptyIrq` is a one-cycle pulse that means the buffer can take another byte. `txEndIrq` is a level that means the line has gone idle. Bit-level serialization and pin timing belong to the shifter and are not part of this block.

Top module: `sertx_buffer`

## Requirements
- R1: After reset, the registers read as follows: mode 0x00, rate 0xFF, control 0x00 and holding byte 0xFF. `flagTdre` and `flagTend` are 1. `txValid`, `txEmptyIrq` and `txEndIrq` are 0.
- R2: The bits per character are 9 − C + P + S, where C is mode bit 6, P is mode bit 5 and S is mode bit 3. One character time is that bit count × 32 × rate × 4^K clocks, where K is mode bits 1:0. Two starts in a row are one character time apart, and `flagTend` rises one character time after the last start.
- R3: A computed character time of 0 (rate 0) behaves as 1 clock.
- R4: A write to the mode register (address 0) or the rate register (address 1) is ignored while control bit 5 (transmit enable) or control bit 4 (receive enable) is set. Otherwise the write takes effect.
- R5: A control write (address 2) with bit 5 set forces both flags to 1. If bit 7 (empty-interrupt enable) is also set, it produces one `txEmptyIrq` pulse in the next cycle. With bit 7 clear, no pulse is produced.
- R6: A data write (address 3) while `flagTend` is 1 starts the byte at once. In the next cycle `txValid` is 1 with that byte, `flagTend` is 0 and `flagTdre` is 1.
- R7: A data write while `flagTend` is 0 stores the byte and clears `flagTdre`, and no new start occurs in the next cycle.
- R8: When the character time expires with `flagTdre` 0, the held byte starts on that cycle.
- R9: When the character time expires with `flagTdre` 1, `flagTend` is set. `txEndIrq` rises with it only if control bit 2 (end-interrupt enable) is set.
- R10: A control write with bit 2 clear drops `txEndIrq`.
- R11: Every start produces a one-cycle `txEmptyIrq` pulse when control bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select: 0 mode, 1 rate, 2 control, 3 data |
| busData | input | 8 | Write data |
| modeQ | output | 8 | Frame-mode register |
| rateQ | output | 8 | Bit-rate divisor register |
| ctrlQ | output | 8 | Control register |
| holdQ | output | 8 | Holding (transmit data) register |
| flagTdre | output | 1 | Holding register free |
| flagTend | output | 1 | Transmitter idle |
| txValid | output | 1 | One-cycle strobe carrying a byte to the shifter |
| txByte | output | 8 | Byte being started |
| txEmptyIrq | output | 1 | Buffer-empty interrupt pulse |
| txEndIrq | output | 1 | Transmit-end interrupt level |

## Verification
The hardest situation to reach is a character timer that expires in the same cycle as a data write. The new byte must then be taken straight from the bus and must not be lost in the holding register. The stimulus gets there by setting the rate to 0, so the character time is one clock, and then writing two bytes on consecutive cycles. The bench also sweeps every combination of the three frame-format bits over several rate and prescale settings. For each combination it checks the spacing between starts and the delay to the end flag against a period it computes itself.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_RATE = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_DATA = 2'd3
  } regAddrE;

  // control register masks
  localparam logic [REG_W-1:0] CTL_TIE  = 8'h80;
  localparam logic [REG_W-1:0] CTL_TE   = 8'h20;
  localparam logic [REG_W-1:0] CTL_RE   = 8'h10;
  localparam logic [REG_W-1:0] CTL_TEIE = 8'h04;

  // mode register field positions
  localparam int MODE_LEN  = 6;
  localparam int MODE_PAR  = 5;
  localparam int MODE_STOP = 3;

  localparam logic [REG_W-1:0] RST_MODE = 8'h00;
  localparam logic [REG_W-1:0] RST_RATE = 8'hFF;
  localparam logic [REG_W-1:0] RST_CTRL = 8'h00;
  localparam logic [REG_W-1:0] RST_HOLD = 8'hFF;

  typedef struct packed {
    logic wrMode;
    logic wrRate;
    logic wrCtrl;
    logic wrHold;
    logic start;
    logic fromBus;
  } dpStrobeT;

endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int OSR   = 32,
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         str,
  input  logic [REG_W-1:0] busData,
  output logic [REG_W-1:0] modeQ,
  output logic [REG_W-1:0] rateQ,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] holdQ,
  output logic [REG_W-1:0] txByte,
  output logic             txValid,
  output logic             timerDone
);

  logic [3:0]       bitCount;
  logic [CNT_W-1:0] basePeriod;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cnt;
  logic             running;

  always_comb begin
    bitCount   = 4'd9 - {3'd0, modeQ[MODE_LEN]} + {3'd0, modeQ[MODE_PAR]}
                      + {3'd0, modeQ[MODE_STOP]};
    basePeriod = CNT_W'(bitCount) * CNT_W'(OSR) * CNT_W'(rateQ);
    period     = basePeriod << {modeQ[1:0], 1'b0};
    reloadVal  = (period == '0) ? '0 : period - CNT_W'(1);
  end

  assign timerDone = running && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= RST_MODE;
      rateQ <= RST_RATE;
      ctrlQ <= RST_CTRL;
      holdQ <= RST_HOLD;
    end else begin
      if (str.wrMode) modeQ <= busData;
      if (str.wrRate) rateQ <= busData;
      if (str.wrCtrl) ctrlQ <= busData;
      if (str.wrHold) holdQ <= busData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= str.start;
      if (str.start) txByte <= str.fromBus ? busData : holdQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (str.start) begin
      cnt     <= reloadVal;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sertx_control.sv
module sertx_control
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [REG_W-1:0] busData,
  input  logic [REG_W-1:0] ctrlQ,
  input  logic             timerDone,
  output dpStrobeT         str,
  output logic             flagTdre,
  output logic             flagTend,
  output logic             txEmptyIrq,
  output logic             txEndIrq
);

  logic             tdreN, tendN, endN, pulseN;
  logic [REG_W-1:0] ctrlEff;
  logic             cfgLocked;

  always_comb begin
    str       = '0;
    tdreN     = flagTdre;
    tendN     = flagTend;
    endN      = txEndIrq;
    pulseN    = 1'b0;
    ctrlEff   = ctrlQ;
    cfgLocked = (ctrlQ & (CTL_TE | CTL_RE)) != '0;

    str.wrMode = busWr && (busAddr == ADDR_MODE) && !cfgLocked;
    str.wrRate = busWr && (busAddr == ADDR_RATE) && !cfgLocked;
    str.wrCtrl = busWr && (busAddr == ADDR_CTRL);
    str.wrHold = busWr && (busAddr == ADDR_DATA);

    if (str.wrCtrl) begin
      ctrlEff = busData;
      if ((busData & CTL_TE) != '0) begin
        tdreN = 1'b1;
        tendN = 1'b1;
        if ((busData & CTL_TIE) != '0) pulseN = 1'b1;
      end
      if ((busData & CTL_TEIE) == '0) endN = 1'b0;
    end

    if (str.wrHold) begin
      if (flagTend) begin
        str.start   = 1'b1;
        str.fromBus = 1'b1;
      end else begin
        tdreN = 1'b0;
      end
    end

    if (timerDone && !str.start) begin
      if (!tdreN) begin
        str.start   = 1'b1;
        str.fromBus = str.wrHold;
      end else begin
        tendN = 1'b1;
        if ((ctrlEff & CTL_TEIE) != '0) endN = 1'b1;
      end
    end

    if (str.start) begin
      tendN = 1'b0;
      tdreN = 1'b1;
      endN  = 1'b0;
      if ((ctrlEff & CTL_TIE) != '0) pulseN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagTdre   <= 1'b1;
      flagTend   <= 1'b1;
      txEmptyIrq <= 1'b0;
      txEndIrq   <= 1'b0;
    end else begin
      flagTdre   <= tdreN;
      flagTend   <= tendN;
      txEmptyIrq <= pulseN;
      txEndIrq   <= endN;
    end
  end

endmodule

// File: rtl/sertx_buffer.sv
module sertx_buffer
  import sertx_pkg::*;
#(
  parameter int OSR = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [REG_W-1:0] busData,
  output logic [REG_W-1:0] modeQ,
  output logic [REG_W-1:0] rateQ,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] holdQ,
  output logic             flagTdre,
  output logic             flagTend,
  output logic             txValid,
  output logic [REG_W-1:0] txByte,
  output logic             txEmptyIrq,
  output logic             txEndIrq
);

  localparam int MAX_BITS   = 11;
  localparam int MAX_RATE   = (1 << REG_W) - 1;
  localparam int MAX_PRESC  = 64;
  localparam int MAX_PERIOD = MAX_BITS * OSR * MAX_RATE * MAX_PRESC;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  dpStrobeT str;
  logic     timerDone;

  sertx_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busData    (busData),
    .ctrlQ      (ctrlQ),
    .timerDone  (timerDone),
    .str        (str),
    .flagTdre   (flagTdre),
    .flagTend   (flagTend),
    .txEmptyIrq (txEmptyIrq),
    .txEndIrq   (txEndIrq)
  );

  sertx_datapath #(.OSR(OSR), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .busData   (busData),
    .modeQ     (modeQ),
    .rateQ     (rateQ),
    .ctrlQ     (ctrlQ),
    .holdQ     (holdQ),
    .txByte    (txByte),
    .txValid   (txValid),
    .timerDone (timerDone)
  );

endmodule

// File: rtl/sertx_checks.sv
module sertx_checks
  import sertx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [REG_W-1:0] busData,
  input logic [REG_W-1:0] modeQ,
  input logic [REG_W-1:0] rateQ,
  input logic [REG_W-1:0] ctrlQ,
  input logic             flagTdre,
  input logic             flagTend,
  input logic             txValid,
  input logic [REG_W-1:0] txByte,
  input logic             txEmptyIrq,
  input logic             txEndIrq
);

  a_r4_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0 && (ctrlQ & (CTL_TE | CTL_RE)) != '0)
      |=> modeQ == $past(modeQ));

  a_r4_rate_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1 && (ctrlQ & (CTL_TE | CTL_RE)) != '0)
      |=> rateQ == $past(rateQ));

  a_r6_immediate_start: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd3 && flagTend)
      |=> (txValid && txByte == $past(busData)));

  a_r6_start_flags: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (flagTdre && !flagTend && !txEndIrq));

  a_r7_hold_or_start: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd3 && !flagTend) |=> (txValid || !flagTdre));

  a_r9_end_level: assert property (@(posedge clk) disable iff (!rstN)
    txEndIrq |-> flagTend);

  a_r11_pulse_enabled: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |-> (ctrlQ & CTL_TIE) != '0);

endmodule

bind sertx_buffer sertx_checks u_checks (.*);

// File: tb/sertx_buffer_test.sv
module sertx_buffer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic [7:0] modeQ, rateQ, ctrlQ, holdQ, txByte;
  logic       flagTdre, flagTend, txValid, txEmptyIrq, txEndIrq;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int starts = 0;
  int lastStart = 0;
  int gap = 0;
  int pulses = 0;
  logic [7:0] lastByte = '0;

  always #2 clk = ~clk;

  sertx_buffer uut (.*);

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      cyc++;
      if (txValid) begin
        starts++;
        gap = cyc - lastStart;
        lastStart = cyc;
        lastByte = txByte;
      end
      if (txEmptyIrq) pulses++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busData = d;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  function automatic int expPeriod(input logic [7:0] m, input int r);
    int bits = 9 - m[6] + m[5] + m[3];
    int p = bits * 32 * r * (1 << (2 * m[1:0]));
    return (p == 0) ? 1 : p;
  endfunction

  task automatic waitStarts(input int n);
    while (starts < n) @(negedge clk);
  endtask

  task automatic runConfig(input logic [7:0] m, input int r);
    int p = expPeriod(m, r);
    int p0, s0;
    logic [7:0] a = 8'h30 + m;
    logic [7:0] b = 8'hC5 ^ m;
    wr(2'd2, 8'h00);
    wr(2'd0, m);
    wr(2'd1, 8'(r));
    check(modeQ == m && rateQ == 8'(r), "R4 unlocked write", modeQ, m);
    p0 = pulses;
    wr(2'd2, 8'hA4);
    check(flagTdre && flagTend && pulses == p0 + 1, "R5 enable pulse", pulses, p0 + 1);
    s0 = starts;
    wr(2'd3, a);
    check(starts == s0 + 1 && lastByte == a && !flagTend && flagTdre,
          "R6 immediate start", lastByte, a);
    wr(2'd3, b);
    check(!flagTdre && starts == s0 + 1, "R7 held byte", starts, s0 + 1);
    waitStarts(s0 + 2);
    check(gap == p && lastByte == b, "R8 R2 held start spacing", gap, p);
    while (!flagTend) @(negedge clk);
    check(cyc - lastStart == p, "R2 end delay", cyc - lastStart, p);
    check(txEndIrq == 1'b1, "R9 end interrupt", txEndIrq, 1);
    check(pulses == p0 + 3, "R11 start pulses", pulses, p0 + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int p0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(modeQ == 8'h00, "R1 mode", modeQ, 0);
    check(rateQ == 8'hFF, "R1 rate", rateQ, 255);
    check(ctrlQ == 8'h00, "R1 ctrl", ctrlQ, 0);
    check(holdQ == 8'hFF, "R1 hold", holdQ, 255);
    check(flagTdre && flagTend, "R1 flags", {flagTdre, flagTend}, 3);
    check(!txValid && !txEmptyIrq && !txEndIrq, "R1 outputs", {txValid, txEmptyIrq, txEndIrq}, 0);

    // R4 lock by transmit enable and by receive enable
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h4B);
    check(modeQ == 8'h00, "R4 mode locked by TE", modeQ, 0);
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h33);
    check(rateQ == 8'hFF, "R4 rate locked by RE", rateQ, 255);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h33);
    check(rateQ == 8'h33, "R4 rate after unlock", rateQ, 51);

    // frame-format sweep (R2, R6..R9, R11)
    for (int k = 0; k < 3; k++) begin
      for (int f = 0; f < 8; f++) begin
        logic [7:0] m = {1'b0, f[2], f[1], 1'b0, f[0], 1'b0, (k == 2) ? 2'd1 : 2'd0};
        runConfig(m, (k == 1) ? 2 : 1);
      end
    end
    runConfig(8'h02, 1);
    runConfig(8'h03, 1);

    // R10 clearing end-interrupt enable, R5 no pulse without TIE
    p0 = pulses;
    wr(2'd2, 8'h20);
    check(txEndIrq == 1'b0, "R10 end interrupt dropped", txEndIrq, 0);
    check(pulses == p0, "R5 no pulse without TIE", pulses, p0);

    // R3 zero period with same-cycle expiry and data write
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h20);
    s0 = starts;
    wr(2'd3, 8'h5A);
    wr(2'd3, 8'hA5);
    @(negedge clk);
    check(starts == s0 + 2 && gap == 1 && lastByte == 8'hA5, "R3 R8 one-clock spacing", gap, 1);
    while (!flagTend) @(negedge clk);
    check(cyc - lastStart == 1, "R3 one-clock end", cyc - lastStart, 1);
    check(txEndIrq == 1'b0, "R9 no end interrupt without enable", txEndIrq, 0);

    finishRun();
  end

endmodule